// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block holds four transmit descriptor slots. Each slot is a pair of 32-bit registers: a start address and a combined command/status word. When the host writes a slot's command/status word, the slot is queued. The engine takes slots strictly in ring order. For the slot at the head of the ring it requests the packet bytes one at a time from a byte-fetch port and stores them in a local FIFO. It starts the wire-side byte stream once enough bytes are buffered. When the packet ends, it writes completion status back into the slot.

The command/status word carries the packet size, an ownership flag, completion flags and an early-start threshold counted in 32-byte units. On completion the engine fills the upper byte with collision and carrier information taken from side inputs. It also pulses one of two completion events for the interrupt logic. The wire side sends one byte per cycle with no backpressure. If the FIFO runs dry before the end of the packet, the packet is cut short and flagged as an underrun.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset every slot register reads 0, `fetch_req` is low and `tx_valid` is low.
- R2: Slot i's status word is at offset 0x10+4*i and its start address at 0x20+4*i. A start address reads back as written. Every other offset reads 0.
- R3: A write to a status word stores the written value with bits 13, 14, 15 and 30 forced to 0, and queues that slot.
- R4: Slots are served strictly in ring order 0,1,2,3,0. While the head slot is not queued, no other queued slot is fetched.
- R5: For the active slot, `fetch_req` is high while bytes remain to fetch and the FIFO holds fewer than FIFO_DEPTH bytes. Byte k is requested at start address + k, and a byte is taken in any cycle where `fetch_req` and `fetch_gnt` are both high.
- R6: Status bit 13 (ownership) is set in the cycle after the last byte of the packet is taken.
- R7: The first wire byte appears in the cycle after the FIFO level reaches L = min(T*32, size, FIFO_DEPTH). T is status bits [20:16], with 0 treated as 1. After that, one byte is sent per cycle while the FIFO is not empty. `tx_first` marks byte 0 and `tx_last` marks byte size-1.
- R8: If the FIFO is empty after the wire side has started and bytes remain, the slot retires at once. Bit 14 is set, bit 15 is clear, bit 13 is set, and `done_err` pulses for that one cycle.
- R9: A packet that sends all its bytes retires in the cycle of its last byte. Bit 15 is set, bit 14 is clear, bit 13 is set, and `done_ok` pulses for that cycle. `done_ok` and `done_err` are never high together.
- R10: On retirement, status bits [31:24] become {carrier_lost_in, 0, late_coll_in, hb_fail_in, coll_cnt_in[3:0]} as sampled in the retiring cycle. Bits [23:16] and [12:0] are kept.
- R11: A queued slot that has not yet retired reads back with bits 13, 14 and 15 clear until the engine finishes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 32 | Address of requested byte |
| fetch_gnt | input | 1 | Fetch accepted this cycle; `fetch_byte` valid |
| fetch_byte | input | 8 | Fetched byte |
| tx_valid | output | 1 | Wire byte valid |
| tx_byte | output | 8 | Wire byte |
| tx_first | output | 1 | First byte of packet |
| tx_last | output | 1 | Last byte of packet |
| coll_cnt_in | input | 4 | Collision count reported on retirement |
| hb_fail_in | input | 1 | Heartbeat failure flag reported on retirement |
| late_coll_in | input | 1 | Late collision flag reported on retirement |
| carrier_lost_in | input | 1 | Carrier lost flag reported on retirement |
| done_ok | output | 1 | Slot retired successfully |
| done_err | output | 1 | Slot retired with underrun |

## Verification
The assertions assume the host never writes a slot's status word while that slot is queued or active. They also assume the host never writes a packet size of zero. The stimulus therefore writes each slot only after the reference model shows it retired, and always uses sizes from 9 to 300 bytes. Fetch grants follow two patterns: one grant every cycle, and one grant every third cycle. The sparse pattern is the one that drives an underrun. No write ever targets the slot the engine is working on.

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  input  logic        fetch_gnt,
  input  logic [7:0]  fetch_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_first,
  output logic        tx_last,
  input  logic [3:0]  coll_cnt_in,
  input  logic        hb_fail_in,
  input  logic        late_coll_in,
  input  logic        carrier_lost_in,
  output logic        done_ok,
  output logic        done_err
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int LW = AW + 1;
  localparam int NSLOT = 4;
  localparam logic [31:0] WR_CLR = 32'h4000_E000;

  logic [31:0] stat [NSLOT];
  logic [31:0] base [NSLOT];
  logic [NSLOT-1:0] pend;
  logic [1:0]  cur;
  logic        run, started;
  logic [12:0] fcnt, scnt;
  logic [7:0]  fifo [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] level;
  logic [13:0] lvl;
  logic [4:0]  tun;

  wire [12:0] size = stat[cur][12:0];
  wire [4:0]  thr  = stat[cur][20:16];
  wire [1:0]  wi   = bus_addr[3:2];
  wire wr_stat = bus_we && bus_addr[7:4] == 4'h1 && bus_addr[1:0] == 2'b00;
  wire wr_base = bus_we && bus_addr[7:4] == 4'h2 && bus_addr[1:0] == 2'b00;

  always_comb begin
    tun = (thr == 5'd0) ? 5'd1 : thr;
    lvl = {4'b0, tun, 5'b0};
    if (14'(size) < lvl) lvl = 14'(size);
    if (14'(FIFO_DEPTH) < lvl) lvl = 14'(FIFO_DEPTH);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr[7:4] == 4'h1) bus_rdata = stat[wi];
      else if (bus_addr[7:4] == 4'h2) bus_rdata = base[wi];
    end
  end

  assign fetch_req  = run && fcnt < size && level < LW'(FIFO_DEPTH);
  assign fetch_addr = base[cur] + 32'(fcnt);
  wire take = fetch_req && fetch_gnt;

  assign tx_valid = run && started && level != '0;
  assign tx_byte  = fifo[rp];
  assign tx_first = tx_valid && scnt == 13'd0;
  assign tx_last  = tx_valid && scnt == size - 13'd1;
  wire under = run && started && level == '0 && scnt < size;
  wire fin   = tx_last || under;
  assign done_ok  = tx_last;
  assign done_err = under;

  always_ff @(posedge clk) begin
    if (take) fifo[wp] <= fetch_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        stat[i] <= '0;
        base[i] <= '0;
      end
      pend <= '0; cur <= '0; run <= 1'b0; started <= 1'b0;
      fcnt <= '0; scnt <= '0; level <= '0; wp <= '0; rp <= '0;
    end else begin
      if (wr_stat) begin
        stat[wi] <= bus_wdata & ~WR_CLR;
        pend[wi] <= 1'b1;
      end
      if (wr_base) base[wi] <= bus_wdata;
      if (!run) begin
        if (pend[cur]) begin
          run <= 1'b1; started <= 1'b0;
          fcnt <= '0; scnt <= '0; level <= '0; wp <= '0; rp <= '0;
        end
      end else if (fin) begin
        stat[cur] <= {carrier_lost_in, 1'b0, late_coll_in, hb_fail_in, coll_cnt_in,
                      stat[cur][23:16], done_ok, under, 1'b1, stat[cur][12:0]};
        pend[cur] <= 1'b0;
        cur <= cur + 2'd1;
        run <= 1'b0;
      end else begin
        if (take) begin
          wp <= wp + 1'b1;
          fcnt <= fcnt + 13'd1;
          if (fcnt == size - 13'd1) stat[cur][13] <= 1'b1;
        end
        if (tx_valid) begin
          rp <= rp + 1'b1;
          scnt <= scnt + 13'd1;
        end
        level <= level + LW'(take) - LW'(tx_valid);
        if (14'(level) >= lvl) started <= 1'b1;
      end
    end
  end

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(FIFO_DEPTH));

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));

  // R4
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |=> (cur == $past(cur) + 2'd1) && !run);

  // R6
  own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fin && fcnt == size - 13'd1) |=> stat[$past(cur)][13]);

  // R7
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_first);

  // R3
  queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !(run && wi == cur)) |=> pend[$past(wi)]);
endmodule

// File: tb/tx_desc_engine_tb.sv
module tx_desc_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fetch_req, fetch_gnt = 0;
  logic [31:0] fetch_addr;
  logic [7:0] fetch_byte;
  logic tx_valid, tx_first, tx_last, done_ok, done_err;
  logic [7:0] tx_byte;
  logic [3:0] coll_cnt_in = 4'h3;
  logic hb_fail_in = 0, late_coll_in = 1, carrier_lost_in = 0;

  int checks = 0, errors = 0, gmode = 0, gcnt = 0, n_ok = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_at(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction
  assign fetch_byte = mem_at(fetch_addr);

  tx_desc_engine #(.FIFO_DEPTH(DEPTH)) u_dut (.*);

  logic [31:0] mstat [4];
  logic [31:0] maddr [4];
  bit mpend [4];
  int mcur, mf, ms;
  bit mrun, mstarted;
  byte unsigned mq [$];
  bit e_freq, e_tv, e_first, e_last, e_err;
  logic [31:0] e_faddr;
  byte unsigned e_tb;
  int e_lvl, msize;

  task automatic calc();
    int t;
    msize = int'(mstat[mcur][12:0]);
    t = int'(mstat[mcur][20:16]);
    if (t == 0) t = 1;
    e_lvl = t * 32;
    if (msize < e_lvl) e_lvl = msize;
    if (DEPTH < e_lvl) e_lvl = DEPTH;
    e_freq  = mrun && mf < msize && mq.size() < DEPTH;
    e_faddr = maddr[mcur] + 32'(mf);
    e_tv    = mrun && mstarted && mq.size() > 0;
    e_tb    = e_tv ? mq[0] : 8'd0;
    e_first = e_tv && ms == 0;
    e_last  = e_tv && ms == msize - 1;
    e_err   = mrun && mstarted && mq.size() == 0 && ms < msize;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mstat[i] = 0; maddr[i] = 0; mpend[i] = 0;
      end
      mcur = 0; mrun = 0; mstarted = 0; mf = 0; ms = 0; mq.delete();
    end else begin
      calc();
      if (!mrun) begin
        if (mpend[mcur]) begin
          mrun = 1; mstarted = 0; mf = 0; ms = 0; mq.delete();
        end
      end else if (e_last || e_err) begin
        mstat[mcur] = {carrier_lost_in, 1'b0, late_coll_in, hb_fail_in, coll_cnt_in,
                       mstat[mcur][23:16], e_last, e_err, 1'b1, mstat[mcur][12:0]};
        mpend[mcur] = 0;
        mcur = (mcur + 1) % 4;
        mrun = 0;
      end else begin
        int pre;
        pre = mq.size();
        if (e_tv) void'(mq.pop_front());
        if (e_freq && fetch_gnt) begin
          mq.push_back(mem_at(e_faddr));
          mf++;
          if (mf == msize) mstat[mcur][13] = 1'b1;
        end
        if (e_tv) ms++;
        if (pre >= e_lvl) mstarted = 1;
      end
      if (bus_we && bus_addr[1:0] == 0 && bus_addr[7:4] == 4'h1) begin
        mstat[bus_addr[3:2]] = bus_wdata & ~32'h4000_E000;
        mpend[bus_addr[3:2]] = 1;
      end
      if (bus_we && bus_addr[1:0] == 0 && bus_addr[7:4] == 4'h2)
        maddr[bus_addr[3:2]] = bus_wdata;
    end
  end

  always @(negedge clk) begin
    gcnt++;
    fetch_gnt = (gmode == 0) ? 1'b1 : (gcnt % 3 == 0);
    if (rst_n) begin
      calc();
      checks++;
      if (fetch_req !== e_freq || (e_freq && fetch_addr !== e_faddr)) begin
        errors++;
        $display("FAIL R5 fetch: req=%0b addr=%h expected req=%0b addr=%h",
                 fetch_req, fetch_addr, e_freq, e_faddr);
      end
      if (tx_valid !== e_tv || tx_first !== e_first || tx_last !== e_last ||
          (e_tv && tx_byte !== e_tb)) begin
        errors++;
        $display("FAIL R7 wire: v=%0b b=%h f=%0b l=%0b expected v=%0b b=%h f=%0b l=%0b",
                 tx_valid, tx_byte, tx_first, tx_last, e_tv, e_tb, e_first, e_last);
      end
      if (done_ok !== e_last) begin
        errors++;
        $display("FAIL R9 done_ok=%0b expected %0b", done_ok, e_last);
      end
      if (done_err !== e_err) begin
        errors++;
        $display("FAIL R8 done_err=%0b expected %0b", done_err, e_err);
      end
      if (done_ok) n_ok++;
      if (done_err) n_err++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!mrun && !mpend[0] && !mpend[1] && !mpend[2] && !mpend[3]) break;
    end
    @(negedge clk);
  endtask

  task automatic check_eq(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(8'h10 + 8'(4*i), 0, "R1");
      rd(8'h20 + 8'(4*i), 0, "R1");
    end
    check_eq(int'(fetch_req), 0, "R1 fetch_req");
    check_eq(int'(tx_valid), 0, "R1 tx_valid");
    // R2 address map
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4*i), 32'h1000 * (i + 1) + 32'(i * 3));
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd(8'h20 + 8'(4*i), 32'h1000 * (i + 1) + 32'(i * 3), "R2");
    rd(8'h30, 0, "R2");
    rd(8'h00, 0, "R2");
    rd(8'h11, 0, "R2");
    // R3 / R11 write clears bits, slot stays pending
    wr(8'h10, 32'h4F04_E014);
    rd(8'h10, 32'h0F04_0014, "R3");
    wait_idle();
    // R6 R9 R10 success writeback
    rd(8'h10, 32'h2304_A014, "R10");
    check_eq(n_ok, 1, "R9 ok count");
    // R4 four slots in ring order (head now slot 1)
    wr(8'h14, 32'h0002_0028);
    wr(8'h18, 32'h0001_0021);
    wr(8'h1C, 32'h0003_0046);
    wr(8'h10, 32'h0004_0009);
    wait_idle();
    for (int i = 0; i < 4; i++) rd(8'h10 + 8'(4*i), mstat[i], "R4");
    check_eq(int'(mstat[0][15]), 1, "R9 slot0 ok");
    check_eq(n_ok, 5, "R4 ok count");
    // R4 head wait: head is slot 1, queue slot 2 only
    wr(8'h18, 32'h0002_0030);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (fetch_req) seen++;
    end
    check_eq(seen, 0, "R4 no fetch while head idle");
    rd(8'h18, 32'h0002_0030, "R11");
    wr(8'h14, 32'h0001_0015);
    wait_idle();
    check_eq(int'(mstat[1][15]), 1, "R4 slot1 ok");
    check_eq(int'(mstat[2][15]), 1, "R4 slot2 ok");
    rd(8'h14, 32'h2301_A015, "R6");
    // R8 underrun with sparse grants (head slot 3)
    gmode = 1;
    wr(8'h1C, 32'h0001_0064);
    wait_idle();
    rd(8'h1C, 32'h2301_6064, "R8");
    check_eq(n_err, 1, "R8 err count");
    // R7 FIFO depth clamp, R10 new side inputs (head slot 0)
    gmode = 0;
    coll_cnt_in = 4'hF; hb_fail_in = 1; late_coll_in = 0; carrier_lost_in = 1;
    wr(8'h10, 32'h001F_012C);
    wait_idle();
    rd(8'h10, 32'h9F1F_A12C, "R10");
    // R7 threshold 0 treated as one unit (head slot 1)
    wr(8'h14, 32'h0000_0032);
    wait_idle();
    rd(8'h14, 32'h9F00_A032, "R7");
    check_eq(n_ok, 9, "R9 final ok count");
    check_eq(n_err, 1, "R8 final err count");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule